// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block sits on the host side of a raw NAND flash device with an 8-bit bus. It turns a single request into the right string of bus cycles. The request names one of three operations (page read, page program or block erase) together with a row and a column address. The block then drives the latch enables, chip enable, the two strobes, the write-protect line and the I/O bus. It polls the shared ready/busy line before it moves page data or reports an end. Every timing figure is a clock-cycle count given as a parameter.

A request is accepted through a valid/ready handshake. Program data arrives as a byte stream with valid/ready. Read data leaves as a byte stream with a one-cycle valid strobe and no back-pressure. Completion is reported on a one-cycle `done` pulse, and a ready/busy timeout is reported on an `err` pulse. After reset the block first waits out a power-up recovery interval. It accepts no request and pulses no strobe until that interval has passed.

Top module: `nand_seq`

## Requirements
- R1: After reset `req_ready` stays low, `nand_we_n` and `nand_re_n` stay high, and `nand_ce_n` stays high for exactly PWRUP_CYCLES clock edges. `req_ready` is high from the next cycle on.
- R2: Each command byte is latched by a rising `nand_we_n` with `nand_cle` high, `nand_ale` low and `nand_re_n` high. The opcode pairs are 00h then 30h for read (`req_op`=0), 80h then 10h for program (`req_op`=1), and 60h then D0h for erase (`req_op`=2 or 3). The two latch enables are never both high.
- R3: Address bytes are latched with `nand_ale` high and `nand_cle` low. Read and program send ADDR_CYCLES bytes: column low byte, column high byte, then row bytes from least significant upward. Erase sends only the ADDR_CYCLES-2 row bytes, in the same order.
- R4: Each write strobe is low for exactly T_WP cycles and then high for at least T_WH cycles. `nand_io_out` does not change while `nand_we_n` is low.
- R5: A program transfers PAGE_BYTES bytes from the `wr_data` stream, in order, each on its own write strobe with both latch enables low. While `wr_valid` is low the block waits with `nand_we_n` high.
- R6: `nand_wp_n` rises at least T_WPS cycles before the first program or erase command is latched. It is low during reads and whenever the block is idle.
- R7: After the closing command the block waits T_WB cycles and then until the synchronised `nand_rb` is high. No read strobe falls and no `done` is given while the line is low.
- R8: A read performs PAGE_BYTES read strobes, each low for exactly T_RP cycles. The byte on `nand_io_in` at the end of each low phase is presented on `rd_data` with a one-cycle `rd_valid`. A read strobe is never low while a write strobe is low.
- R9: `nand_ce_n` is low for every strobe and for the whole sequence of an operation. It is high again once the block returns to idle after `done` or `err`.
- R10: If ready/busy stays low for BUSY_TIMEOUT cycles of polling, the block pulses `err`, gives no `done`, releases chip enable and write protect, and returns to idle.
- R11: Each completed operation gives exactly one single-cycle `done` pulse. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 read, 1 program, 2 or 3 erase |
| req_row | input | 24 | Page/block row address |
| req_col | input | 16 | Column address |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte valid strobe |
| done | output | 1 | Operation completed pulse |
| err | output | 1 | Ready/busy timeout pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | Bus value driven by the host |
| nand_io_oe | output | 1 | Host drives the bus |
| nand_io_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Ready/busy, low while busy |

## Verification
The hardest situation to reach is a busy line that never returns high, with the block then forced to abandon the operation and release the bus cleanly. The bench contains a device model that responds to the closing command. The model can be told to hold ready/busy low indefinitely for one operation, both during a program and during a read. The bench then checks the length of the wait, the error pulse, the released chip enable and write protect, and that no read strobe was issued. Gaps in the program stream are made by dropping `wr_valid` at random, so the stall path at the start of a data cycle is exercised repeatedly.

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq #(
  parameter int unsigned ADDR_CYCLES  = 5,
  parameter int unsigned PAGE_BYTES   = 2112,
  parameter int unsigned PWRUP_CYCLES = 2000,
  parameter int unsigned T_WP         = 3,
  parameter int unsigned T_WH         = 2,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RH         = 2,
  parameter int unsigned T_WB         = 20,
  parameter int unsigned T_WPS        = 20,
  parameter int unsigned BUSY_TIMEOUT = 200000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [23:0] req_row,
  input  logic [15:0] req_col,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        err,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb
);
  typedef enum logic [3:0] {S_PWR, S_IDLE, S_WPS, S_CMD1, S_ADDR, S_DIN,
                            S_CMD2, S_TWB, S_BUSY, S_DOUT} st_t;
  st_t st;
  logic [1:0]  op;
  logic [23:0] row;
  logic [15:0] col;
  logic [2:0]  aidx, nadr, eidx;
  logic [31:0] cnt, tcnt, bcnt;
  logic [7:0]  io_q, abyte, io_nx;
  logic        rb_m, rb_s, wcyc, stall, wend, rend, is_prog, is_erase;

  assign is_prog  = op == 2'd1;
  assign is_erase = op[1];
  assign nadr  = is_erase ? 3'(ADDR_CYCLES - 2) : 3'(ADDR_CYCLES);
  assign eidx  = is_erase ? aidx + 3'd2 : aidx;
  assign wcyc  = st inside {S_CMD1, S_ADDR, S_DIN, S_CMD2};
  assign stall = st == S_DIN && cnt == 0 && !wr_valid;
  assign wend  = wcyc && cnt == T_WP + T_WH;
  assign rend  = st == S_DOUT && cnt == T_RP + T_RH;

  assign req_ready   = st == S_IDLE;
  assign wr_ready    = st == S_DIN && cnt == 0;
  assign nand_ce_n   = st == S_PWR || st == S_IDLE;
  assign nand_cle    = st == S_CMD1 || st == S_CMD2;
  assign nand_ale    = st == S_ADDR;
  assign nand_we_n   = !(wcyc && cnt >= 1 && cnt <= T_WP);
  assign nand_re_n   = !(st == S_DOUT && cnt >= 1 && cnt <= T_RP);
  assign nand_io_out = io_q;
  assign nand_io_oe  = wcyc;

  always_comb
    case (eidx)
      3'd0:    abyte = col[7:0];
      3'd1:    abyte = col[15:8];
      3'd2:    abyte = row[7:0];
      3'd3:    abyte = row[15:8];
      default: abyte = row[23:16];
    endcase

  always_comb
    case (st)
      S_CMD1:  io_nx = is_erase ? 8'h60 : (is_prog ? 8'h80 : 8'h00);
      S_CMD2:  io_nx = is_erase ? 8'hD0 : (is_prog ? 8'h10 : 8'h30);
      S_ADDR:  io_nx = abyte;
      default: io_nx = wr_data;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWR; op <= '0; row <= '0; col <= '0; aidx <= '0;
      cnt <= '0; tcnt <= '0; bcnt <= '0; io_q <= '0;
      rb_m <= 1'b0; rb_s <= 1'b0; nand_wp_n <= 1'b0;
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rb_m <= nand_rb;
      rb_s <= rb_m;
      done <= 1'b0;
      err <= 1'b0;
      rd_valid <= 1'b0;
      if (wcyc && cnt == 0 && !stall) io_q <= io_nx;
      case (st)
        S_PWR: begin
          tcnt <= tcnt + 1;
          if (tcnt == PWRUP_CYCLES - 1) st <= S_IDLE;
        end
        S_IDLE:
          if (req_valid) begin
            op <= req_op; row <= req_row; col <= req_col;
            aidx <= '0; bcnt <= '0; cnt <= '0; tcnt <= '0;
            if (req_op == 2'd0) st <= S_CMD1;
            else begin
              nand_wp_n <= 1'b1;
              st <= S_WPS;
            end
          end
        S_WPS: begin
          tcnt <= tcnt + 1;
          if (tcnt == T_WPS - 1) st <= S_CMD1;
        end
        S_CMD1, S_ADDR, S_DIN, S_CMD2:
          if (wend) begin
            cnt <= '0;
            case (st)
              S_CMD1: st <= S_ADDR;
              S_ADDR:
                if (aidx == nadr - 3'd1) st <= is_prog ? S_DIN : S_CMD2;
                else aidx <= aidx + 3'd1;
              S_DIN: begin
                bcnt <= bcnt + 1;
                if (bcnt == PAGE_BYTES - 1) st <= S_CMD2;
              end
              default: begin
                st <= S_TWB;
                tcnt <= '0;
              end
            endcase
          end else if (!stall) cnt <= cnt + 1;
        S_TWB: begin
          tcnt <= tcnt + 1;
          if (tcnt == T_WB - 1) begin
            st <= S_BUSY;
            tcnt <= '0;
          end
        end
        S_BUSY:
          if (rb_s) begin
            if (!is_prog && !is_erase) begin
              st <= S_DOUT; cnt <= '0; bcnt <= '0;
            end else begin
              done <= 1'b1; nand_wp_n <= 1'b0; st <= S_IDLE;
            end
          end else if (tcnt == BUSY_TIMEOUT - 1) begin
            err <= 1'b1; nand_wp_n <= 1'b0; st <= S_IDLE;
          end else tcnt <= tcnt + 1;
        S_DOUT: begin
          if (cnt == T_RP) begin
            rd_data <= nand_io_in;
            rd_valid <= 1'b1;
          end
          if (rend) begin
            cnt <= '0;
            bcnt <= bcnt + 1;
            if (bcnt == PAGE_BYTES - 1) begin
              done <= 1'b1;
              st <= S_IDLE;
            end
          end else cnt <= cnt + 1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R9
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R4
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_out));
  // R6
  wp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) && nand_cle && (nand_io_out == 8'h80 || nand_io_out == 8'h60))
      |-> nand_wp_n);
  // R7
  read_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> rb_s);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R11
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
endmodule

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb;
  localparam int AC = 5, PG = 16, PW = 60, TWP = 3, TWH = 2, TRP = 3, TRH = 2;
  localparam int TWB = 4, TWPS = 5, TO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [7:0] wr_data = '0, rd_data, nand_io_out, nand_io_in;
  logic wr_valid = 1'b0, wr_ready, rd_valid, done, err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;
  logic rb_m = 1'b1;

  always #2.5 clk = ~clk;

  nand_seq #(.ADDR_CYCLES(AC), .PAGE_BYTES(PG), .PWRUP_CYCLES(PW), .T_WP(TWP),
             .T_WH(TWH), .T_RP(TRP), .T_RH(TRH), .T_WB(TWB), .T_WPS(TWPS),
             .BUSY_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_wp_n(nand_wp_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(rb_m));

  int errors = 0, checks = 0;
  int ncmd, naddr, ndata, nread, nrdv, we_low, re_low, wp_hi, busy_left, since, strobes;
  int cur_busy, wr_idx;
  logic pwe = 1'b1, pre = 1'b1, re_busy, hang = 1'b0, prog_on = 1'b0, pv = 1'b0, pr = 1'b0;
  logic busy_seen;
  logic [7:0] io_fall;
  logic [7:0] cmd_log [4];
  logic [7:0] addr_log [8];
  logic [23:0] cur_row = '0;

  function automatic logic [7:0] rdpat(logic [23:0] r, int i);
    return r[7:0] ^ 8'(i * 29 + 3);
  endfunction
  function automatic logic [7:0] wrpat(logic [23:0] r, int i);
    return r[15:8] + 8'(i * 7 + 1);
  endfunction
  function automatic logic [7:0] cmd_a(logic [1:0] op);
    return op[1] ? 8'h60 : (op == 2'd1 ? 8'h80 : 8'h00);
  endfunction
  function automatic logic [7:0] cmd_b(logic [1:0] op);
    return op[1] ? 8'hD0 : (op == 2'd1 ? 8'h10 : 8'h30);
  endfunction
  function automatic int addr_n(logic [1:0] op);
    return op[1] ? AC - 2 : AC;
  endfunction
  function automatic logic [7:0] addr_b(logic [1:0] op, logic [23:0] r, logic [15:0] c, int i);
    logic [39:0] a;
    int e;
    a = {r, c};
    e = op[1] ? i + 2 : i;
    return a[e*8 +: 8];
  endfunction

  assign nand_io_in = rdpat(cur_row, nread);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    wp_hi = nand_wp_n ? wp_hi + 1 : 0;
    if (!nand_we_n) begin
      if (pwe) begin we_low = 1; io_fall = nand_io_out; end
      else we_low++;
      strobes++;
    end else if (!pwe) begin
      chk(we_low == TWP, "R4 write strobe low width", we_low, TWP);
      chk(nand_io_out == io_fall, "R4 bus held while strobe low", nand_io_out, io_fall);
      chk(!nand_ce_n, "R9 chip enable low at latch", nand_ce_n, 0);
      if (nand_cle && !nand_ale) begin
        if (ncmd < 4) cmd_log[ncmd] = nand_io_out;
        ncmd++;
        if (nand_io_out == 8'h80 || nand_io_out == 8'h60)
          chk(nand_wp_n && wp_hi >= TWPS, "R6 protect released early enough", wp_hi, TWPS);
        if (nand_io_out == 8'h00)
          chk(!nand_wp_n, "R6 protect low on read", nand_wp_n, 0);
        if (nand_io_out == 8'h30 || nand_io_out == 8'h10 || nand_io_out == 8'hD0) begin
          busy_left = hang ? 1000000 : cur_busy;
          busy_seen = 1'b1;
          since = 0;
        end
      end else if (nand_ale && !nand_cle) begin
        if (naddr < 8) addr_log[naddr] = nand_io_out;
        naddr++;
      end else if (!nand_ale && !nand_cle) begin
        chk(nand_io_out == wrpat(cur_row, ndata), "R5 program byte", nand_io_out,
            wrpat(cur_row, ndata));
        ndata++;
      end else chk(1'b0, "R2 both latch enables high", 1, 0);
    end
    pwe = nand_we_n;
    if (!nand_re_n) begin
      if (pre) begin re_low = 1; re_busy = 1'b0; end
      else re_low++;
      if (!rb_m) re_busy = 1'b1;
      strobes++;
    end else if (!pre) begin
      chk(re_low == TRP, "R8 read strobe low width", re_low, TRP);
      chk(!re_busy, "R7 read strobe while busy", re_busy, 0);
      nread++;
    end
    pre = nand_re_n;
    if (rd_valid) begin
      chk(rd_data == rdpat(cur_row, nrdv), "R8 read byte", rd_data, rdpat(cur_row, nrdv));
      nrdv++;
    end
    if (done) chk(rb_m && busy_seen, "R7 done only after ready", rb_m, 1);
    if (busy_left > 0) busy_left--;
    if (!hang && busy_left > 100000) busy_left = 0;
    rb_m = (busy_left == 0);
    since++;
    if (prog_on) begin
      if (pv && pr) wr_idx++;
      wr_valid = (wr_idx < PG) && ($urandom % 3 != 0);
      wr_data = wrpat(cur_row, wr_idx);
    end else wr_valid = 1'b0;
    pv = wr_valid;
    pr = wr_ready;
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) step();
  endtask

  task automatic run_op(input logic [1:0] op, input logic [23:0] r, input logic [15:0] c,
                        input int blen, input bit hg);
    bit got_done, got_err;
    int w;
    ncmd = 0; naddr = 0; ndata = 0; nread = 0; nrdv = 0; busy_seen = 1'b0;
    cur_row = r; cur_busy = blen; hang = hg; wr_idx = 0; prog_on = (op == 2'd1);
    while (!req_ready) tick();
    req_valid = 1'b1; req_op = op; req_row = r; req_col = c;
    tick();
    req_valid = 1'b0;
    got_done = 1'b0; got_err = 1'b0; w = 0;
    while (!got_done && !got_err && w < 20000) begin
      tick(); w++; got_done = done; got_err = err;
    end
    chk(ncmd == 2, "R2 command count", ncmd, 2);
    chk(cmd_log[0] == cmd_a(op), "R2 opening opcode", cmd_log[0], cmd_a(op));
    chk(cmd_log[1] == cmd_b(op), "R2 closing opcode", cmd_log[1], cmd_b(op));
    chk(naddr == addr_n(op), "R3 address cycle count", naddr, addr_n(op));
    for (int i = 0; i < addr_n(op) && i < 8; i++)
      chk(addr_log[i] == addr_b(op, r, c, i), "R3 address byte", addr_log[i], addr_b(op, r, c, i));
    if (op == 2'd1) chk(ndata == PG, "R5 program byte count", ndata, PG);
    if (hg) begin
      chk(got_err && !got_done, "R10 timeout reported", {got_err, got_done}, 2);
      chk(since >= TO, "R10 waited the full timeout", since, TO);
      chk(nread == 0 && nrdv == 0, "R7 no read while busy", nread, 0);
    end else begin
      chk(got_done && !got_err, "R11 done reported", {got_done, got_err}, 2);
      if (op == 2'd0) chk(nrdv == PG && nread == PG, "R8 read byte count", nrdv, PG);
    end
    chk(nand_ce_n, "R9 chip enable released at end", nand_ce_n, 1);
    tick();
    chk(!done && !err, "R11 single-cycle end pulse", {done, err}, 0);
    chk(!nand_wp_n, "R6 protect low when idle", nand_wp_n, 0);
    prog_on = 1'b0;
    hang = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    ncmd = 0; naddr = 0; ndata = 0; nread = 0; nrdv = 0; we_low = 0; re_low = 0;
    wp_hi = 0; busy_left = 0; since = 0; strobes = 0; cur_busy = 1; wr_idx = 0;
    re_busy = 1'b0; busy_seen = 1'b0; io_fall = '0;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 idle bus in reset",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(!nand_wp_n, "R6 protect low in reset", nand_wp_n, 0);
    chk(!req_ready && !done && !err, "R1 not ready in reset", req_ready, 0);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 1000) begin tick(); n++; end
    chk(n == PW, "R1 power-up wait length", n, PW);
    chk(strobes == 0, "R1 no strobe during power-up wait", strobes, 0);
    chk(nand_ce_n, "R9 chip enable high when idle", nand_ce_n, 1);
    run_op(2'd0, 24'h012345, 16'h0004, 20, 1'b0);
    run_op(2'd1, 24'h00ABCD, 16'h0000, 35, 1'b0);
    run_op(2'd2, 24'h1F2E3D, 16'hFFFF, 10, 1'b0);
    run_op(2'd3, 24'hFFFFFF, 16'h1234, 1, 1'b0);
    run_op(2'd1, 24'h00C0DE, 16'h0010, 0, 1'b1);
    run_op(2'd0, 24'h0BEEF0, 16'h0800, 0, 1'b1);
    for (int k = 0; k < 14; k++)
      run_op(2'($urandom % 4), 24'($urandom), 16'($urandom), 1 + int'($urandom % 60), 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule